// File: doc/BRIEF.md
# Reset Cause and Soft Reset Control Register

A single 32-bit memory-mapped register that keeps a record of the cause of the most recent system reset and lets software ask for a soft reset. Five bits at the top of the word are implemented. Three of them are cause flags: the power-on flag and two button causes. Software clears these flags by writing ones. The other two are soft request bits, one for a power-on-style reset and one for an externally initiated reset. Writing a one sets the bit and also raises a one-cycle system reset request pulse.

The platform reports every system reset it carries out on `sys_rst_i`. A saturating counter tracks whether that reset is the first one since power-on. Only the first reset, or the first reset after a soft power-on request, loads the register with the power-on flag alone. Any later reset leaves the contents unchanged. The reset tree itself and the button debouncing lie outside this block. The button cause events arrive already conditioned as single-cycle pulses.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst_ni` is deasserted, the register reads 0x00000000, `sys_rst_req_o` is low and the power-on counter is zero.
- R2: Only byte address 0xF024 selects the register. A read of 0xF020, or of any other address, returns zero. A write to any other address has no effect.
- R3: Bits 26:0 always read zero and ignore writes. The implemented mask is 0xF8000000.
- R4: Bits 31 (power-on cause), 28 (button power-on cause) and 27 (button external-reset cause) are write-one-to-clear. Writing a zero to one of them leaves it unchanged.
- R5: Bits 30 (soft power-on request) and 29 (soft external-reset request) are set by writing a one. Writing a zero does not clear them.
- R6: A write with bit 30 set zeroes the power-on counter. On the following cycle `sys_rst_req_o` is high for exactly one cycle.
- R7: A write with bit 29 set and bit 30 clear also gives a one-cycle request pulse on the following cycle. A write with both bits set gives only one pulse.
- R8: A `sys_rst_i` cycle while the counter is zero loads the register with exactly 0x80000000. The counter then increments.
- R9: A `sys_rst_i` cycle while the counter is nonzero leaves the register unchanged. The counter saturates at 2^CNT_W-1, so any number of further resets never sets the power-on flag again.
- R10: A pulse on `btn_por_i` sets bit 28 and a pulse on `btn_xir_i` sets bit 27. If a clear of the same bit falls in the same cycle, the set wins.
- R11: A register write in a cycle where `sys_rst_i` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| addr_i | input | ADDR_W (16) | Byte address of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| sys_rst_i | input | 1 | Platform indicates that a system reset is being applied |
| btn_por_i | input | 1 | Button power-on reset event |
| btn_xir_i | input | 1 | Button external reset event |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall in the same cycle. A platform reset can coincide with a software write, and a button event can coincide with a write-one-to-clear of its own flag. The directed part of the bench drives each pair on a single clock edge. It checks that the write is dropped during the reset, and that the button flag survives its own clear. The random part drives reset, button and write strobes independently. This produces further collisions, and each is judged against a bench model that applies the stated priority: reset load first, then the write, then the button set.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef logic [31:0] word_t;

  localparam int unsigned POR_BIT  = 31;
  localparam int unsigned SPOR_BIT = 30;
  localparam int unsigned SXIR_BIT = 29;
  localparam int unsigned BPOR_BIT = 28;
  localparam int unsigned BXIR_BIT = 27;

  localparam word_t IMPL_MASK = 32'hF800_0000;
  localparam word_t W1C_MASK  = 32'h9800_0000;
  localparam word_t W1S_MASK  = 32'h6000_0000;
  localparam word_t POR_ONLY  = 32'h8000_0000;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hF024
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              sys_rst_i,
  output logic              hit_o,
  output logic              wr_o
);
  assign hit_o = (addr_i == REG_OFFSET);
  // writes are dropped while the platform applies a reset
  assign wr_o  = we_i && hit_o && !sys_rst_i;
endmodule

// File: rtl/rsc_por_track.sv
module rsc_por_track #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);

  // R9
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  // R6
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> first_o);
endmodule

// File: rtl/rsc_status.sv
module rsc_status
  import rsc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  word_t wdata_i,
  input  logic  load_por_i,
  input  logic  bpor_i,
  input  logic  bxir_i,
  output word_t status_o,
  output logic  soft_por_o,
  output logic  req_o
);
  word_t status_q, status_d, wv;
  logic  req_q;

  assign wv         = wdata_i & IMPL_MASK;
  assign soft_por_o = wr_i && wv[SPOR_BIT];

  always_comb begin
    status_d = status_q;
    if (load_por_i) status_d = POR_ONLY;
    else if (wr_i)  status_d = (status_q & ~(wv & W1C_MASK)) | (wv & W1S_MASK);
    // hardware set wins over a same-cycle clear
    if (bpor_i) status_d[BPOR_BIT] = 1'b1;
    if (bxir_i) status_d[BXIR_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      req_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      req_q    <= wr_i && (wv[SPOR_BIT] || wv[SXIR_BIT]);
    end
  end

  assign status_o = status_q;
  assign req_o    = req_q;

  // R3
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~IMPL_MASK) == '0);
  // R8
  por_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_por_i && !bpor_i && !bxir_i |=> status_q == POR_ONLY);
  // R4
  w1c_por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !load_por_i && wdata_i[POR_BIT] |=> !status_q[POR_BIT]);
  // R10
  btn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpor_i |=> status_q[BPOR_BIT]);
  // R7
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(wr_i && (wdata_i[SPOR_BIT] || wdata_i[SXIR_BIT])));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hF024,
  parameter int unsigned CNT_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              sys_rst_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic              sys_rst_req_o
);
  logic  hit, wr, first, soft_por;
  word_t status;

  rsc_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_decode (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .sys_rst_i (sys_rst_i),
    .hit_o     (hit),
    .wr_o      (wr)
  );

  rsc_por_track #(.CNT_W(CNT_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_por),
    .inc_i   (sys_rst_i),
    .first_o (first)
  );

  rsc_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .wdata_i    (wdata_i),
    .load_por_i (sys_rst_i && first),
    .bpor_i     (btn_por_i),
    .bxir_i     (btn_xir_i),
    .status_o   (status),
    .soft_por_o (soft_por),
    .req_o      (sys_rst_req_o)
  );

  assign rdata_o = hit ? status : '0;

  // R9
  later_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i && !first && !btn_por_i && !btn_xir_i |=> $stable(status));
  // R11
  rst_wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i && !first && !btn_por_i && !btn_xir_i && we_i |=> $stable(status));
  // R2
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i != REG_OFFSET |-> rdata_o == '0);
endmodule

// File: tb/rst_cause_reg_tb.sv
`timescale 1ns/1ps
module rst_cause_reg_tb;
  localparam int unsigned CNT_W = 2;
  localparam logic [15:0] A_REG = 16'hF024;
  localparam logic [15:0] A_LO  = 16'hF020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = A_REG;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst = 1'b0, bp = 1'b0, bx = 1'b0;
  logic        req;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_reg = '0;
  int          m_cnt = 0;
  logic        m_req = 1'b0;

  always #4 clk = ~clk;

  rst_cause_reg #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .sys_rst_i(sys_rst), .btn_por_i(bp), .btn_xir_i(bx),
    .sys_rst_req_o(req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // bench model of one clock edge
  task automatic model(logic w, logic [15:0] a, logic [31:0] d, logic s, logic p, logic x);
    logic [31:0] v;
    v = d & 32'hF800_0000;
    m_req = 1'b0;
    if (s) begin
      if (m_cnt == 0) m_reg = 32'h8000_0000;
      if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
    end else if (w && a == A_REG) begin
      m_reg = (m_reg & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
      if (v[30]) begin m_cnt = 0; m_req = 1'b1; end
      else if (v[29]) m_req = 1'b1;
    end
    if (p) m_reg[28] = 1'b1;
    if (x) m_reg[27] = 1'b1;
  endtask

  task automatic step(string tag, logic w, logic [15:0] a, logic [31:0] d,
                      logic s, logic p, logic x);
    @(negedge clk);
    we = w; addr = a; wdata = d; sys_rst = s; bp = p; bx = x;
    @(posedge clk);
    model(w, a, d, s, p, x);
    #1;
    we = 1'b0; addr = A_REG; sys_rst = 1'b0; bp = 1'b0; bx = 1'b0;
    #1;
    chk({tag, " reg"}, rdata, m_reg);
    chk({tag, " req"}, {31'b0, req}, {31'b0, m_req});
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
    addr = A_REG;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd("R1 reset value", A_REG, 32'h0);
    chk("R1 req idle", {31'b0, req}, 32'h0);

    step("R8 first reset loads por", 0, A_REG, 0, 1, 0, 0);
    chk("R8 exact value", rdata, 32'h8000_0000);
    step("R2 write lower word", 1, A_LO, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R2 lower word reads zero", A_LO, 32'h0);
    step("R2 write other addr", 1, 16'h1234, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R2 other addr reads zero", 16'h1234, 32'h0);
    step("R3 low bits ignored", 1, A_REG, 32'h07FF_FFFF, 0, 0, 0);
    chk("R3 exact", rdata, 32'h8000_0000);
    step("R5 R7 soft xir", 1, A_REG, 32'h2000_0000, 0, 0, 0);
    chk("R7 pulse high", {31'b0, req}, 32'h1);
    step("R6 pulse one cycle", 0, A_REG, 0, 0, 0, 0);
    chk("R6 pulse low", {31'b0, req}, 32'h0);
    step("R4 clear por", 1, A_REG, 32'h8000_0000, 0, 0, 0);
    chk("R4 exact", rdata, 32'h2000_0000);
    step("R5 zero keeps set", 1, A_REG, 32'h0, 0, 0, 0);
    chk("R5 exact", rdata, 32'h2000_0000);
    step("R9 later reset unchanged", 0, A_REG, 0, 1, 0, 0);
    chk("R9 exact", rdata, 32'h2000_0000);
    step("R7 both bits", 1, A_REG, 32'h6000_0000, 0, 0, 0);
    chk("R7 single req", {31'b0, req}, 32'h1);
    step("R7 no second pulse", 0, A_REG, 0, 0, 0, 0);
    chk("R7 req low", {31'b0, req}, 32'h0);
    step("R6 counter cleared", 0, A_REG, 0, 1, 0, 0);
    chk("R6 por after soft por", rdata, 32'h8000_0000);
    step("R10 set beats clear", 1, A_REG, 32'h1000_0000, 0, 1, 0);
    chk("R10 bit28", rdata, 32'h9000_0000);
    step("R10 xir set", 0, A_REG, 0, 0, 0, 1);
    chk("R10 bit27", rdata, 32'h9800_0000);
    step("R4 clear buttons", 1, A_REG, 32'h1800_0000, 0, 0, 0);
    chk("R4 buttons cleared", rdata, 32'h8000_0000);
    step("R11 write during reset", 1, A_REG, 32'h8000_0000, 1, 0, 0);
    chk("R11 exact", rdata, 32'h8000_0000);
    chk("R11 no req", {31'b0, req}, 32'h0);
    step("R4 clear por again", 1, A_REG, 32'h8000_0000, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R9 saturate", 0, A_REG, 0, 1, 0, 0);
    chk("R9 no por after many resets", rdata, 32'h0);

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int unsigned k;
      k = $urandom_range(0, 9);
      a = (k < 7) ? A_REG : (k == 7 ? A_LO : 16'($urandom));
      step("R2 R4 R5 R6 R8 R10 random", ($urandom_range(0, 2) != 0), a, $urandom,
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0),
           ($urandom_range(0, 11) == 0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule